// File: doc/BRIEF.md
# Multi-Lane Radix Digit Adder

This block adds two big-integer operands held as vectors of digits, one digit per lane, in a number base chosen at run time. Every lane forms the plain sum of its two digits. From that sum it flags whether it creates a carry on its own (sum at or above the radix) or would pass an incoming carry through (sum exactly one below the radix).

The flags of all lanes are packed into two words. One wide addition, ((P|G)+G+cin)^P, then yields the carry entering every lane at once, so no carry ripples lane by lane. Each lane adds its resolved carry and brings the result back into range with at most one subtraction of the radix.

A caller presents both digit vectors, the radix and a carry-in with a one-cycle valid strobe. The result digits and the carry leaving the top lane come out registered on the following cycle. Chaining several invocations into a longer number is left to the caller: it feeds the carry-out back as the next carry-in.

Top module: `radix_lane_adder`

## Requirements
- R1: While reset is held, and after it is released until the first strobe, out_valid is 0, every result digit is 0 and carry_out is 0.
- R2: out_valid is high in exactly the cycle after a cycle with in_valid high, and the result for that request is present in the same cycle.
- R3: Lane i occupies bits [16*i+15:16*i] of a_digits, b_digits and sum_digits (lane 0 least significant). The result digit is (a_i + b_i + carry into lane i) mod radix, for operand digits below the radix.
- R4: A lane whose digit sum is at least the radix (generate) sends a carry into the next lane, whatever its incoming carry.
- R5: A lane whose digit sum equals radix-1 (propagate) passes its incoming carry on unchanged. A lane that neither generates nor propagates sends no carry.
- R6: carry_in is the carry entering lane 0.
- R7: carry_out is the carry leaving the top lane, so an unbroken propagate run from carry_in through every lane sets it.
- R8: The radix is taken per request in the range 2 to 65536. 65536 gives plain binary 16-bit digits and 2 gives one-bit digits.
- R9: In cycles with in_valid low the registered result digits and carry_out keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| a_digits | input | 16*LANES | First operand, one digit per lane |
| b_digits | input | 16*LANES | Second operand, one digit per lane |
| radix | input | 17 | Number base, 2 to 65536 |
| carry_in | input | 1 | Carry into lane 0 |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| sum_digits | output | 16*LANES | Result digits, each below the radix |
| carry_out | output | 1 | Carry out of the top lane |

## Verification
The bench goes after the carry chains a ripple-free resolver most easily gets wrong. Its cases include a full run of radix-1 digits lit by carry_in, which must zero every lane and raise carry_out. A design that drops the carry-in term or reads the propagate flag off by one lane would leave nines in place or lose carry_out. A propagate run broken by one quiet lane must stop there, and a wrong mask would leak the carry beyond the break.

Radix 65536 and radix 2 test the compare and subtract at the extremes of the 17-bit base. A width slip would wrap the digits or miss a generate. Random radices with random in-range digits are checked against a lane-by-lane ripple model. The hold check catches a design that loads its result register on every cycle.

// File: rtl/radix_lane_adder.sv
module radix_lane_adder #(
  parameter int LANES = 8,
  parameter int DW    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [LANES*DW-1:0] a_digits,
  input  logic [LANES*DW-1:0] b_digits,
  input  logic [DW:0]         radix,
  input  logic                carry_in,
  output logic                out_valid,
  output logic [LANES*DW-1:0] sum_digits,
  output logic                carry_out
);
  localparam int RW = DW + 1;

  logic [LANES-1:0]    gen_v;
  logic [LANES-1:0]    prop_v;
  logic [LANES:0]      carry_v;
  logic [LANES*DW-1:0] lane_res;

  // single-step resolution: bit i is the carry entering lane i
  assign carry_v = ({1'b0, prop_v | gen_v} + {1'b0, gen_v} + {{LANES{1'b0}}, carry_in})
                   ^ {1'b0, prop_v};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [RW-1:0] raw;
    logic [RW-1:0] tot;
    logic [RW-1:0] red;

    assign raw       = {1'b0, a_digits[i*DW +: DW]} + {1'b0, b_digits[i*DW +: DW]};
    assign gen_v[i]  = raw >= radix;
    assign prop_v[i] = raw == (radix - {{(RW-1){1'b0}}, 1'b1});
    assign tot       = raw + {{(RW-1){1'b0}}, carry_v[i]};
    assign red       = (tot >= radix) ? (tot - radix) : tot;
    assign lane_res[i*DW +: DW] = red[DW-1:0];

    assert_digit_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && ({1'b0, a_digits[i*DW +: DW]} < radix) && ({1'b0, b_digits[i*DW +: DW]} < radix))
        |-> ({1'b0, lane_res[i*DW +: DW]} < radix));
    assert_generate_carries_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && gen_v[i]) |-> carry_v[i+1]);
    assert_propagate_passes_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && prop_v[i] && !gen_v[i]) |-> (carry_v[i+1] == carry_v[i]));
    assert_quiet_lane_kills_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !prop_v[i] && !gen_v[i]) |-> !carry_v[i+1]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      sum_digits <= '0;
      carry_out  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        sum_digits <= lane_res;
        carry_out  <= carry_v[LANES];
      end
    end
  end

  assert_lane0_carry_in_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (carry_v[0] == carry_in));
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && $past(rst_n)) |=> ($stable(sum_digits) && $stable(carry_out)));
endmodule

// File: tb/radix_lane_adder_tb.sv
module radix_lane_adder_tb;
  localparam int LANES = 8;
  localparam int DW    = 16;
  localparam int VW    = 17 + 1 + 2*LANES*DW + 1;
  localparam int NV    = 9;

  // entry: {radix, carry_in, a, b, expected carry_out}
  localparam logic [VW-1:0] VEC [NV] = '{
    {17'd10,    1'b0, {8{16'd9}},      {8{16'd0}},                  1'b0},
    {17'd10,    1'b1, {8{16'd9}},      {8{16'd0}},                  1'b1},
    {17'h10000, 1'b0, {8{16'hFFFF}},   {{7{16'd0}}, 16'd1},         1'b1},
    {17'd2,     1'b0, {8{16'd1}},      {8{16'd0}},                  1'b0},
    {17'd2,     1'b1, {8{16'd1}},      {8{16'd0}},                  1'b1},
    {17'd7,     1'b0, {{7{16'd0}}, 16'd6}, {{7{16'd0}}, 16'd6},     1'b0},
    {17'd7,     1'b0, {16'd5, {7{16'd0}}}, {16'd5, {7{16'd0}}},     1'b1},
    {17'd100,   1'b1, {16'd50,16'd99,16'd0,16'd49,16'd99,16'd99,16'd1,16'd98},
                      {16'd49,16'd0,16'd0,16'd50,16'd0,16'd0,16'd98,16'd1}, 1'b0},
    {17'd65535, 1'b1, {8{16'hFFFE}},   {8{16'hFFFE}},               1'b1}
  };

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                in_valid = 1'b0;
  logic [LANES*DW-1:0] a_digits = '0;
  logic [LANES*DW-1:0] b_digits = '0;
  logic [DW:0]         radix = 17'd10;
  logic                carry_in = 1'b0;
  logic                out_valid;
  logic [LANES*DW-1:0] sum_digits;
  logic                carry_out;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  radix_lane_adder #(.LANES(LANES), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a_digits(a_digits),
    .b_digits(b_digits), .radix(radix), .carry_in(carry_in),
    .out_valid(out_valid), .sum_digits(sum_digits), .carry_out(carry_out)
  );

  function automatic void ripple_ref(input logic [DW:0] r, input logic ci,
                                     input logic [LANES*DW-1:0] a, input logic [LANES*DW-1:0] b,
                                     output logic [LANES*DW-1:0] s, output logic co);
    logic c;
    logic [DW+1:0] t;
    c = ci;
    s = '0;
    for (int i = 0; i < LANES; i++) begin
      t = {2'b0, a[i*DW +: DW]} + {2'b0, b[i*DW +: DW]} + {{(DW+1){1'b0}}, c};
      if (t >= {1'b0, r}) begin
        t = t - {1'b0, r};
        c = 1'b1;
      end else begin
        c = 1'b0;
      end
      s[i*DW +: DW] = t[DW-1:0];
    end
    co = c;
  endfunction

  task automatic check(input string req, input logic [LANES*DW-1:0] act, input logic [LANES*DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [DW:0] r, input logic ci,
                       input logic [LANES*DW-1:0] a, input logic [LANES*DW-1:0] b);
    @(negedge clk);
    radix = r; carry_in = ci; a_digits = a; b_digits = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 out_valid", {{(LANES*DW-1){1'b0}}, out_valid}, {{(LANES*DW-1){1'b0}}, 1'b1});
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [LANES*DW-1:0] es;
    logic eco;
    logic [LANES*DW-1:0] hold_s;
    logic hold_c;

    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 out_valid", {{(LANES*DW-1){1'b0}}, out_valid}, '0);
    check("R1 sum_digits", sum_digits, '0);
    check("R1 carry_out", {{(LANES*DW-1){1'b0}}, carry_out}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", {sum_digits[LANES*DW-2:0], carry_out}, '0);

    // table: R3 R4 R5 R6 R7 R8
    for (int k = 0; k < NV; k++) begin
      logic [DW:0] r;
      logic ci, xco;
      logic [LANES*DW-1:0] a, b;
      {r, ci, a, b, xco} = VEC[k];
      ripple_ref(r, ci, a, b, es, eco);
      apply(r, ci, a, b);
      check("R3 R8 table digits", sum_digits, es);
      check("R7 R6 table carry_out", {{(LANES*DW-1){1'b0}}, carry_out}, {{(LANES*DW-1){1'b0}}, xco});
    end

    // directed: R5 full propagate chain zeroes every lane
    apply(17'd10, 1'b1, {8{16'd9}}, '0);
    check("R5 chain digits", sum_digits, '0);

    // R2: valid drops one cycle after strobe ends
    @(negedge clk);
    check("R2 out_valid low", {{(LANES*DW-1){1'b0}}, out_valid}, '0);

    // R9: idle inputs do not disturb result
    apply(17'd1000, 1'b0, {8{16'd999}}, {8{16'd3}});
    hold_s = sum_digits; hold_c = carry_out;
    @(negedge clk);
    radix = 17'd3; carry_in = 1'b1; a_digits = '0; b_digits = {8{16'd1}};
    repeat (3) @(negedge clk);
    check("R9 hold digits", sum_digits, hold_s);
    check("R9 hold carry", {{(LANES*DW-1){1'b0}}, carry_out}, {{(LANES*DW-1){1'b0}}, hold_c});

    // random radices against ripple model: R3 R8
    for (int k = 0; k < 200; k++) begin
      logic [DW:0] r;
      logic ci;
      logic [LANES*DW-1:0] a, b;
      r = 17'(2 + ($urandom % 65535));
      ci = 1'($urandom);
      for (int i = 0; i < LANES; i++) begin
        a[i*DW +: DW] = 16'($urandom % r);
        b[i*DW +: DW] = 16'($urandom % r);
        if (k % 4 == 0) b[i*DW +: DW] = 16'(r - 17'd1 - {1'b0, a[i*DW +: DW]});
      end
      ripple_ref(r, ci, a, b, es, eco);
      apply(r, ci, a, b);
      check("R3 random digits", sum_digits, es);
      check("R7 random carry_out", {{(LANES*DW-1){1'b0}}, carry_out}, {{(LANES*DW-1){1'b0}}, eco});
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule